// File: doc/BRIEF.md
# IN Endpoint Transfer Progress Tracker

This block holds the transfer-size register of one device IN endpoint and follows a transfer as it moves through the transmit FIFO. Software programs three fields through a single 32-bit register: a byte count, a packet count and a packets-per-microframe count. Two different hardware events then consume the transfer. A fill event, raised when a packet from memory has been written into the FIFO, takes that packet's length off the byte count. A drain event, raised when a packet has been read out of the FIFO, takes one off the packet count.

When both counts have run out after a nonzero transfer was programmed, a sticky completion flag is raised for software. Software drops the flag with a one-cycle clear strobe. Programming the byte count to one maximum packet size therefore gives one completion per packet. For periodic endpoints, the block also gives the data PID of the next isochronous packet in the current microframe. That PID follows from the per-microframe packet count, steps on every drain and starts again on each start-of-microframe pulse.

Top module: `ep_xfer_tracker`

## Requirements
- R1: After synchronous reset the register reads 0, `xfer_irq` is 0 and `iso_pid` is 0 (DATA0).
- R2: A write with `reg_wr` loads the register in one cycle. Bits 18:0 hold the byte count, bits 28:19 the packet count and bits 30:29 the per-microframe count. Bit 31 ignores writes and always reads 0.
- R3: A cycle with `fifo_wr` lowers the byte count by `fifo_wr_len`. The count stops at 0 when the length exceeds it.
- R4: A cycle with `fifo_rd` lowers the packet count by one. A packet count of 0 stays 0.
- R5: When a register write falls in the same cycle as a fill or drain event, the register takes the written value and the decrement is lost.
- R6: `xfer_irq` rises on the clock edge that leaves both counts at 0, provided nonzero counts were written before. Writing all-zero counts never raises it.
- R7: `xfer_irq` stays high until a cycle with `irq_clr`. If completion and `irq_clr` fall in the same cycle, the flag is set.
- R8: `iso_pid` codes are 0 = DATA0, 1 = DATA1 and 2 = DATA2. At the start of a microframe the PID is DATA2 for a per-microframe count of 3, DATA1 for 2, and DATA0 for 1 or 0.
- R9: Each `fifo_rd` steps `iso_pid` down by one, and it stays at DATA0 once there. A `uf_start` pulse returns it to the starting PID and takes priority over a drain in the same cycle.
- R10: With the byte count set to one packet's length and the packet count set to 1, each fill followed by a drain raises one completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| fifo_wr | input | 1 | Fill event: one packet written into the transmit FIFO |
| fifo_wr_len | input | 19 | Byte length of the packet on a fill event |
| fifo_rd | input | 1 | Drain event: one packet read out of the transmit FIFO |
| uf_start | input | 1 | Start-of-microframe pulse |
| irq_clr | input | 1 | Clear strobe for the completion flag |
| iso_pid | output | 2 | Data PID of the next isochronous packet |
| xfer_irq | output | 1 | Sticky transfer-complete flag |

## Verification
The bench uses the default widths: a 19-bit byte count, a 10-bit packet count and the 2-bit per-microframe field. The random writes keep the packet count below 8 and the byte count below a few thousand. Random fill lengths up to 700 bytes then often run the byte count past zero, so saturation and completion happen many times, in both orders of the two counts reaching zero. A separate directed pass writes all ones and so reaches the field limits and the reserved bit.

// File: rtl/ep_xfer_pkg.sv
package ep_xfer_pkg;

    // Width of the per-microframe packet count; fixed by the bus protocol.
    localparam int MC_W = 2;

    typedef enum logic [1:0] {
        PID_DATA0 = 2'd0,
        PID_DATA1 = 2'd1,
        PID_DATA2 = 2'd2
    } iso_pid_e;

    // Hardware events that consume a transfer.
    typedef struct packed {
        logic fill;   // packet written into the FIFO
        logic drain;  // packet read out of the FIFO
        logic sof;    // start of microframe
    } fifo_evt_t;

    // PID of the first packet in a microframe for a given packet count.
    function automatic iso_pid_e first_pid(input logic [MC_W-1:0] mc);
        case (mc)
            2'd3:    return PID_DATA2;
            2'd2:    return PID_DATA1;
            default: return PID_DATA0;
        endcase
    endfunction

endpackage

// File: rtl/ep_xfer_counters.sv
module ep_xfer_counters #(
    parameter int BYTE_W = 19,
    parameter int PKT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_bytes,
    input  logic [PKT_W-1:0]  load_pkts,
    input  logic              dec_bytes,
    input  logic [BYTE_W-1:0] dec_len,
    input  logic              dec_pkt,
    output logic [BYTE_W-1:0] bytes_q,
    output logic [PKT_W-1:0]  pkts_q,
    output logic [BYTE_W-1:0] bytes_nxt,
    output logic [PKT_W-1:0]  pkts_nxt
);

    always_comb begin
        bytes_nxt = bytes_q;
        pkts_nxt  = pkts_q;
        if (load) begin
            bytes_nxt = load_bytes;
            pkts_nxt  = load_pkts;
        end else begin
            if (dec_bytes)
                bytes_nxt = (dec_len >= bytes_q) ? '0 : bytes_q - dec_len;
            if (dec_pkt && (pkts_q != '0))
                pkts_nxt = pkts_q - PKT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            pkts_q  <= '0;
        end else begin
            bytes_q <= bytes_nxt;
            pkts_q  <= pkts_nxt;
        end
    end

endmodule

// File: rtl/ep_iso_pid_seq.sv
module ep_iso_pid_seq
    import ep_xfer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [MC_W-1:0] mc,
    input  logic            uf_start,
    input  logic            pkt_sent,
    output iso_pid_e        pid
);

    logic [MC_W-1:0] idx_q;
    logic [1:0]      start_code;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (uf_start)
            idx_q <= '0;
        else if (pkt_sent && (idx_q != '1))
            idx_q <= idx_q + MC_W'(1);
    end

    always_comb begin
        start_code = 2'(first_pid(mc));
        if (start_code > 2'(idx_q))
            pid = iso_pid_e'(start_code - 2'(idx_q));
        else
            pid = PID_DATA0;
    end

endmodule

// File: rtl/ep_xfer_tracker.sv
module ep_xfer_tracker
    import ep_xfer_pkg::*;
#(
    parameter int BYTE_W = 19,
    parameter int PKT_W  = 10,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              fifo_wr,
    input  logic [BYTE_W-1:0] fifo_wr_len,
    input  logic              fifo_rd,
    input  logic              uf_start,
    input  logic              irq_clr,
    output logic [1:0]        iso_pid,
    output logic              xfer_irq
);

    localparam int PKT_LO = BYTE_W;
    localparam int MC_LO  = BYTE_W + PKT_W;
    localparam int USED_W = MC_LO + MC_W;

    fifo_evt_t         evt;
    logic [BYTE_W-1:0] wr_bytes, bytes_q, bytes_nxt;
    logic [PKT_W-1:0]  wr_pkts, pkts_q, pkts_nxt;
    logic [MC_W-1:0]   mc_q;
    logic              armed_q, irq_q, done;
    iso_pid_e          pid;
    logic              unused_rsv;

    assign evt.fill  = fifo_wr;
    assign evt.drain = fifo_rd;
    assign evt.sof   = uf_start;

    assign wr_bytes   = reg_wdata[0 +: BYTE_W];
    assign wr_pkts    = reg_wdata[PKT_LO +: PKT_W];
    assign unused_rsv = ^reg_wdata[REG_W-1:USED_W];

    ep_xfer_counters #(
        .BYTE_W (BYTE_W),
        .PKT_W  (PKT_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (reg_wr),
        .load_bytes (wr_bytes),
        .load_pkts  (wr_pkts),
        .dec_bytes  (evt.fill),
        .dec_len    (fifo_wr_len),
        .dec_pkt    (evt.drain),
        .bytes_q    (bytes_q),
        .pkts_q     (pkts_q),
        .bytes_nxt  (bytes_nxt),
        .pkts_nxt   (pkts_nxt)
    );

    ep_iso_pid_seq u_pid (
        .clk      (clk),
        .rst      (rst),
        .mc       (mc_q),
        .uf_start (evt.sof),
        .pkt_sent (evt.drain),
        .pid      (pid)
    );

    // Completion: an armed transfer whose counts both land on zero.
    assign done = !reg_wr && armed_q && (bytes_nxt == '0) && (pkts_nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q    <= '0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                mc_q    <= reg_wdata[MC_LO +: MC_W];
                armed_q <= (wr_bytes != '0) || (wr_pkts != '0);
            end else if (done) begin
                armed_q <= 1'b0;
            end
            if (done)
                irq_q <= 1'b1;
            else if (irq_clr)
                irq_q <= 1'b0;
        end
    end

    assign reg_rdata = REG_W'({mc_q, pkts_q, bytes_q});
    assign iso_pid   = 2'(pid);
    assign xfer_irq  = irq_q;

endmodule

// File: rtl/ep_xfer_tracker_chk.sv
module ep_xfer_tracker_chk
    import ep_xfer_pkg::*;
#(
    parameter int BYTE_W = 19,
    parameter int PKT_W  = 10,
    parameter int REG_W  = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             fifo_rd,
    input logic             uf_start,
    input logic             irq_clr,
    input logic [1:0]       iso_pid,
    input logic             xfer_irq
);

    localparam int PKT_LO = BYTE_W;
    localparam int MC_LO  = BYTE_W + PKT_W;
    localparam int USED_W = MC_LO + MC_W;
    localparam logic [REG_W-1:0] USED_MASK = REG_W'((64'd1 << USED_W) - 64'd1);

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1] == 1'b0);

    // R5
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> reg_rdata == ($past(reg_wdata) & USED_MASK));

    // R4
    pkt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd && !reg_wr && (reg_rdata[PKT_LO +: PKT_W] != '0))
        |=> reg_rdata[PKT_LO +: PKT_W] == PKT_W'($past(reg_rdata[PKT_LO +: PKT_W]) - 1));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_irq && !irq_clr) |=> xfer_irq);

    // R9
    sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (uf_start && !reg_wr) |=> iso_pid == 2'(first_pid(reg_rdata[MC_LO +: MC_W])));

endmodule

bind ep_xfer_tracker ep_xfer_tracker_chk #(
    .BYTE_W (BYTE_W),
    .PKT_W  (PKT_W),
    .REG_W  (REG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .fifo_rd   (fifo_rd),
    .uf_start  (uf_start),
    .irq_clr   (irq_clr),
    .iso_pid   (iso_pid),
    .xfer_irq  (xfer_irq)
);

// File: tb/test_ep_xfer_tracker.sv
module test_ep_xfer_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fifo_wr = 1'b0;
    logic [18:0] fifo_wr_len = '0;
    logic        fifo_rd = 1'b0;
    logic        uf_start = 1'b0;
    logic        irq_clr = 1'b0;
    logic [1:0]  iso_pid;
    logic        xfer_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model of the register and flags
    logic [1:0]  m_mc = '0;
    logic [9:0]  m_pkt = '0;
    logic [18:0] m_bytes = '0;
    bit          m_armed = 0;
    bit          m_irq = 0;
    int          m_idx = 0;

    always #10 clk = ~clk;

    ep_xfer_tracker i_ep_xfer_tracker (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_wr(fifo_wr), .fifo_wr_len(fifo_wr_len),
        .fifo_rd(fifo_rd), .uf_start(uf_start), .irq_clr(irq_clr),
        .iso_pid(iso_pid), .xfer_irq(xfer_irq)
    );

    function automatic logic [31:0] exp_reg();
        return {1'b0, m_mc, m_pkt, m_bytes};
    endfunction

    function automatic logic [1:0] exp_pid();
        int first;
        first = (m_mc == 2'd3) ? 2 : (m_mc == 2'd2) ? 1 : 0;
        return (first > m_idx) ? 2'(first - m_idx) : 2'd0;
    endfunction

    task automatic model_update();
        bit done;
        done = 0;
        if (reg_wr) begin
            m_mc    = reg_wdata[30:29];
            m_pkt   = reg_wdata[28:19];
            m_bytes = reg_wdata[18:0];
            m_armed = (m_pkt != 0) || (m_bytes != 0);
        end else begin
            if (fifo_wr) m_bytes = (fifo_wr_len >= m_bytes) ? 19'd0 : m_bytes - fifo_wr_len;
            if (fifo_rd && m_pkt != 0) m_pkt = m_pkt - 10'd1;
            done = m_armed && m_bytes == 0 && m_pkt == 0;
            if (done) m_armed = 0;
        end
        if (done) m_irq = 1;
        else if (irq_clr) m_irq = 0;
        if (uf_start) m_idx = 0;
        else if (fifo_rd && m_idx < 3) m_idx = m_idx + 1;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: inputs already driven at the negedge; compare at next negedge
    task automatic cycle(string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk(tag, "reg", reg_rdata, exp_reg());
        chk("R6", "irq", 32'(xfer_irq), 32'(m_irq));
        chk("R9", "pid", 32'(iso_pid), 32'(exp_pid()));
        reg_wr = 0; fifo_wr = 0; fifo_rd = 0; uf_start = 0; irq_clr = 0;
        fifo_wr_len = '0;
    endtask

    task automatic wr(logic [31:0] d);
        reg_wr = 1; reg_wdata = d;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "reg", reg_rdata, 32'h0);
        chk("R1", "irq", 32'(xfer_irq), 32'h0);
        chk("R1", "pid", 32'(iso_pid), 32'h0);

        // R2 full write, reserved bit dropped; R8 mc=3 gives DATA2
        wr(32'hFFFF_FFFF); cycle("R2");
        chk("R2", "reg", reg_rdata, 32'h7FFF_FFFF);
        chk("R8", "pid", 32'(iso_pid), 32'd2);

        // R5 write beats fill and drain in same cycle
        wr(32'h2010_0064); fifo_wr = 1; fifo_wr_len = 19'd50; fifo_rd = 1; cycle("R5");
        chk("R5", "reg", reg_rdata, 32'h2010_0064);

        // R10 one packet per transfer -> one completion
        wr(32'h2008_0040); cycle("R10");
        fifo_wr = 1; fifo_wr_len = 19'd64; cycle("R3");
        chk("R3", "reg", reg_rdata, 32'h2008_0000);
        chk("R6", "irq", 32'(xfer_irq), 32'h0);
        fifo_rd = 1; cycle("R4");
        chk("R10", "irq", 32'(xfer_irq), 32'h1);
        cycle("R7");
        chk("R7", "irq", 32'(xfer_irq), 32'h1);
        irq_clr = 1; cycle("R7");
        chk("R7", "irq", 32'(xfer_irq), 32'h0);
        // R7 set wins over clear
        wr(32'h2008_0040); cycle("R10");
        fifo_wr = 1; fifo_wr_len = 19'd64; cycle("R10");
        fifo_rd = 1; irq_clr = 1; cycle("R7");
        chk("R7", "irq", 32'(xfer_irq), 32'h1);
        irq_clr = 1; cycle("R7");

        // R3 saturation; byte-only transfer completes
        wr(32'h0000_000A); cycle("R3");
        fifo_wr = 1; fifo_wr_len = 19'd500; cycle("R3");
        chk("R3", "reg", reg_rdata, 32'h0);
        chk("R6", "irq", 32'(xfer_irq), 32'h1);
        irq_clr = 1; cycle("R7");
        // R4 packet count stays at zero
        fifo_rd = 1; cycle("R4");
        chk("R4", "reg", reg_rdata, 32'h0);
        // R6 zero program never completes
        wr(32'h0); cycle("R6");
        repeat (3) cycle("R6");
        chk("R6", "irq", 32'(xfer_irq), 32'h0);

        // R9 PID stepping within microframe
        wr(32'h6000_0000); cycle("R9");
        uf_start = 1; cycle("R9");
        chk("R9", "pid", 32'(iso_pid), 32'd2);
        fifo_rd = 1; cycle("R9");
        chk("R9", "pid", 32'(iso_pid), 32'd1);
        fifo_rd = 1; cycle("R9");
        fifo_rd = 1; cycle("R9");
        chk("R9", "pid", 32'(iso_pid), 32'd0);
        uf_start = 1; fifo_rd = 1; cycle("R9");
        chk("R9", "pid", 32'(iso_pid), 32'd2);
        // R8 other counts
        wr(32'h4000_0000); uf_start = 1; cycle("R8");
        chk("R8", "pid", 32'(iso_pid), 32'd1);
        wr(32'h2000_0000); cycle("R8");
        chk("R8", "pid", 32'(iso_pid), 32'd0);

        // random mix checked against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 20 == 0)
                wr({1'($urandom), 2'($urandom), 10'($urandom % 7), 19'($urandom % 3000)});
            fifo_wr = ($urandom % 3 == 0);
            fifo_wr_len = 19'($urandom % 700);
            fifo_rd = ($urandom % 3 == 0);
            uf_start = ($urandom % 16 == 0);
            irq_clr = ($urandom % 10 == 0);
            cycle("R5");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule